// File: doc/BRIEF.md
# Windowed Line Sync Counter

This block measures how many horizontal sync pulses make up each video frame. A pulse is counted only when the acceptance-window flag from the line-locking PLL is high in the same clock cycle. Pulses outside the window are treated as noise or equalising pulses and are dropped. Qualified pulses go first to a small prescaler that divides by four, and its carry advances a saturating main counter.

Each vertical sync strobe captures the main counter into an 8-bit holding register and starts the count for the next frame. Software can read the holding register at any time. A read never disturbs the counting. A fresh-value flag shows that a new frame result has been captured since the last read. All inputs are single-cycle strobes in the block clock domain. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `line_sync_counter`

## Requirements
- R1: After reset, `line_count_o` is 0 and `fresh_o` is 0.
- R2: A cycle with `hs_strobe_i` high adds to the frame count only if `in_window_i` is also high in that cycle. A cycle where only `in_window_i` is high adds nothing.
- R3: At a vertical sync, `line_count_o` takes the value floor(P/4), where P is the number of qualified pulses in the frame that just ended. The new value is visible from the clock edge after the `vs_strobe_i` cycle.
- R4: `line_count_o` changes only in the cycle right after a `vs_strobe_i` cycle. Between vertical syncs it holds its value.
- R5: A qualified pulse in the same cycle as `vs_strobe_i` is not part of the value captured at that sync. It counts as the first pulse of the new frame.
- R6: When a frame has 1020 or more qualified pulses, the captured value is 255. The counter stops at 255 and does not wrap.
- R7: `rd_strobe_i` has no effect on `line_count_o` or on the count being built for the current frame.
- R8: `fresh_o` goes to 1 in the cycle after each `vs_strobe_i`. It goes to 0 in the cycle after a `rd_strobe_i` that is not in the same cycle as a `vs_strobe_i`. When a read and a vertical sync fall in the same cycle, the sync wins and `fresh_o` becomes 1.
- R9: A frame with no qualified pulses, including two vertical syncs on back-to-back cycles, captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_strobe_i | input | 1 | One-cycle strobe for a detected horizontal sync pulse |
| in_window_i | input | 1 | PLL acceptance window is open in this cycle |
| vs_strobe_i | input | 1 | One-cycle vertical sync strobe: captures the count and starts a new frame |
| rd_strobe_i | input | 1 | Register read strobe; clears the fresh flag |
| line_count_o | output | 8 | Captured count for the last frame, divided by four |
| fresh_o | output | 1 | A new value has been captured since the last read |

## Verification
The internal prescaler and counter are visible only through the value captured at the next vertical sync. A wrong internal state therefore shows up at the ports up to one full frame late, one cycle after that sync. A prescaler phase that is off by one changes the result only at frame sizes near a multiple of four. For this reason the frame sizes used are chosen to sit on either side of those boundaries and of the 1020-pulse saturation point. Faults in the holding register or the fresh flag appear within one cycle of a sync or read strobe.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned LSC_CNT_W = 8;
  localparam int unsigned LSC_PRE_W = 2;
endpackage

// File: rtl/lsc_prescaler.sv
module lsc_prescaler #(
  parameter int unsigned PRE_W = lsc_pkg::LSC_PRE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic clr_i,
  output logic carry_o
);
  localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     pre_q <= '0;
    else if (clr_i) pre_q <= inc_i ? PRE_W'(1) : '0;
    else if (inc_i) pre_q <= pre_q + 1'b1;
  end

  assign carry_o = inc_i && !clr_i && (pre_q == PRE_TOP);

  // R5: a pulse in the sync cycle opens the new frame with a phase of one
  p_new_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && inc_i |=> pre_q == PRE_W'(1));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !inc_i |=> pre_q == '0);
  // R2: an unqualified cycle leaves the prescaler phase unchanged
  p_hold_unqual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i && !clr_i |=> $stable(pre_q));
endmodule

// File: rtl/lsc_sat_counter.sv
module lsc_sat_counter #(
  parameter int unsigned CNT_W = lsc_pkg::LSC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (step_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_MAX && !clr_i |=> cnt_q == CNT_MAX);
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/lsc_holding.sv
module lsc_holding #(
  parameter int unsigned CNT_W = lsc_pkg::LSC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             fresh_o
);
  logic [CNT_W-1:0] hold_q;
  logic             fresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (cap_i) hold_q <= cnt_i;
      if (cap_i)     fresh_q <= 1'b1;
      else if (rd_i) fresh_q <= 1'b0;
    end
  end

  assign hold_o  = hold_q;
  assign fresh_o = fresh_q;

  p_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(hold_q));
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> hold_q == $past(cnt_i));
  p_fresh_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> fresh_q);
  p_fresh_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && !cap_i |=> !fresh_q);
endmodule

// File: rtl/line_sync_counter.sv
module line_sync_counter #(
  parameter int unsigned CNT_W = lsc_pkg::LSC_CNT_W,
  parameter int unsigned PRE_W = lsc_pkg::LSC_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_strobe_i,
  input  logic             in_window_i,
  input  logic             vs_strobe_i,
  input  logic             rd_strobe_i,
  output logic [CNT_W-1:0] line_count_o,
  output logic             fresh_o
);
  logic             qual;
  logic             carry;
  logic [CNT_W-1:0] frame_cnt;

  assign qual = hs_strobe_i && in_window_i;

  lsc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (qual),
    .clr_i   (vs_strobe_i),
    .carry_o (carry)
  );

  lsc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (carry),
    .clr_i  (vs_strobe_i),
    .cnt_o  (frame_cnt)
  );

  lsc_holding #(.CNT_W(CNT_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (vs_strobe_i),
    .rd_i    (rd_strobe_i),
    .cnt_i   (frame_cnt),
    .hold_o  (line_count_o),
    .fresh_o (fresh_o)
  );

  // R7: a read alone never moves the reported value
  p_read_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_i && !vs_strobe_i |=> $stable(line_count_o));
  // R1: the checked-out state after reset is zero
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> line_count_o == '0 && !fresh_o);
endmodule

// File: tb/line_sync_counter_tb.sv
`timescale 1ns/1ps
module line_sync_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs = 1'b0, win = 1'b0, vs = 1'b0, rd = 1'b0;
  logic [7:0] cnt;
  logic       fresh;

  int checks = 0;
  int fails  = 0;
  int model_pulses = 0;
  int last_exp = 0;
  int exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  line_sync_counter u_dut (
    .clk(clk), .rst_n(rst_n), .hs_strobe_i(hs), .in_window_i(win),
    .vs_strobe_i(vs), .rd_strobe_i(rd), .line_count_o(cnt), .fresh_o(fresh)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulses(input int n, input bit w);
    for (int i = 0; i < n; i++) begin
      hs = 1'b1; win = w;
      @(negedge clk);
      if (w) model_pulses++;
    end
    hs = 1'b0; win = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: ends a frame and queues the expected captured value
  task automatic vsync(input bit with_pulse, input bit with_rd, input string req);
    int e;
    e = model_pulses / 4;
    if (e > 255) e = 255;
    exp_q.push_back(e);
    tag_q.push_back(req);
    last_exp = e;
    vs = 1'b1; hs = with_pulse; win = with_pulse; rd = with_rd;
    @(negedge clk);
    vs = 1'b0; hs = 1'b0; win = 1'b0; rd = 1'b0;
    model_pulses = with_pulse ? 1 : 0;
  endtask

  // monitor: pops one expected item per observed vertical sync
  always @(posedge clk) begin
    if (rst_n && vs) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 scoreboard empty", cnt, -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cnt == e[7:0], t, cnt, e);
      end
      check(fresh == 1'b1, "R8 fresh after sync", fresh, 1);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    check(cnt == 8'd0, "R1 count after reset", cnt, 0);
    check(fresh == 1'b0, "R1 fresh after reset", fresh, 0);
    rst_n = 1'b1;
    idle(2);

    // R9: empty frame
    vsync(1'b0, 1'b0, "R9 empty frame");
    idle(2);

    // R2/R3: 9 qualified, 6 out-of-window, window-only cycles
    pulses(5, 1'b1); pulses(6, 1'b0);
    win = 1'b1; idle(4); win = 1'b0;
    pulses(4, 1'b1);
    check(cnt == last_exp[7:0], "R4 hold between syncs", cnt, last_exp);
    vsync(1'b0, 1'b0, "R2 R3 windowed 9 pulses");
    idle(3);
    check(cnt == 8'd2, "R4 value kept", cnt, 2);

    // R5: pulse on the sync cycle belongs to the new frame
    pulses(7, 1'b1);
    vsync(1'b1, 1'b0, "R5 frame before pulse-sync");
    pulses(3, 1'b1);
    vsync(1'b0, 1'b0, "R5 pulse in sync cycle counted");
    idle(2);

    // R3 boundaries: 3 and 4 pulses
    pulses(3, 1'b1);
    vsync(1'b0, 1'b0, "R3 three pulses");
    pulses(4, 1'b1);
    vsync(1'b0, 1'b0, "R3 four pulses");

    // R6: saturation edges
    pulses(1019, 1'b1);
    vsync(1'b0, 1'b0, "R6 1019 pulses");
    pulses(1020, 1'b1);
    vsync(1'b0, 1'b0, "R6 1020 pulses");
    pulses(1100, 1'b1);
    vsync(1'b0, 1'b0, "R6 1100 pulses no wrap");

    // R7: reads mid-frame leave value and count untouched
    pulses(6, 1'b1);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    check(cnt == 8'd255, "R7 value after read", cnt, 255);
    check(fresh == 1'b0, "R8 fresh cleared by read", fresh, 0);
    pulses(2, 1'b1);
    rd = 1'b1; hs = 1'b1; win = 1'b1; @(negedge clk);
    rd = 1'b0; hs = 1'b0; win = 1'b0; model_pulses++;
    check(cnt == 8'd255, "R7 value after second read", cnt, 255);
    vsync(1'b0, 1'b0, "R7 count unaffected by reads");

    // R8: read and sync in one cycle -> flag stays set
    pulses(4, 1'b1);
    vsync(1'b0, 1'b1, "R8 read with sync");
    idle(1);
    check(fresh == 1'b1, "R8 sync wins over read", fresh, 1);

    // R9: back-to-back syncs
    pulses(8, 1'b1);
    vsync(1'b0, 1'b0, "R9 before back-to-back");
    vsync(1'b0, 1'b0, "R9 back-to-back sync");
    idle(3);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule